// File: doc/BRIEF.md
# Pipelined CORDIC Magnitude and Phase Unit

This block converts a signed fixed-point complex sample, given as a real and an imaginary part, into polar form. It reports the length of the vector and its phase angle. The datapath is a fully pipelined CORDIC vectoring chain with one micro-rotation per register stage, so a new sample can enter on every clock. A strobe marks each valid input. The matching output strobe follows after a fixed number of cycles.

Before the iterations, a folding stage takes the absolute value of both parts. It puts the larger one on the x path and the smaller one on the y path, so the vector always starts inside the first half-quadrant. This replaces the usual first rotation by pi/4. After the iterations, a two-step unfolding stage rebuilds the full-circle angle from flags that travel down the pipeline with each sample.

A constant multiply built from canonical-signed-digit shift-add terms can remove the CORDIC gain from the magnitude. The angle is given either in radians or as a signed fraction of pi. Parameter limits are 8 <= WL <= 24 and 1 <= NITER <= WL-1.

Top module: `cmp_polar`

## Requirements
- R1: Folding uses |re| and |im|. The larger one becomes x and the smaller one becomes y (0 <= y <= x). The case |re| <= |im| counts as swapped, and its angle is rebuilt as pi/2 minus the iterated angle.
- R2: Each of the NITER micro-rotations i = 1..NITER takes one register stage, shifts by i and uses a constant step of atan(2^-i). A sample is accepted on every clock in which valid_in is high, including back-to-back clocks.
- R3: valid_out is high exactly NITER+4 rising edges after the edge that sampled the matching valid_in. It is low while rst_n (asynchronous, active low) is asserted.
- R4: With gain compensation on (GAIN_COMP=1), magnitude is an unsigned WL+1 bit integer within a few LSB of sqrt(re^2+im^2). It is never negative.
- R5: With gain compensation off, magnitude equals sqrt(re^2+im^2) times the product of sqrt(1+2^-2i) over i = 1..NITER. The term for i = 0 is not included.
- R6: In normalized mode (ANGLE_RADIANS=0), angle is a signed WL+3 bit value with WL+2 fraction bits that equals atan2(im,re)/pi. It covers [-1,1), so an angle of +pi wraps to -1.
- R7: In radian mode (ANGLE_RADIANS=1), angle is a signed WL+3 bit value with WL fraction bits that equals atan2(im,re) in radians.
- R8: The quadrant is restored from the input signs. re<0 and im<0 gives -pi+a. re<0 and im>=0 gives pi-a. re>=0 and im<0 gives -a. Otherwise the angle is a, where a is the octant-corrected angle.
- R9: Inputs on the axes, including the most negative code on either axis, give the exact axis angle and the exact length, within tolerance.
- R10: A zero input gives a magnitude of exactly 0. Its angle is left undefined and is not forced to any value.
- R11: Clocks with valid_in low produce no output strobe. The number of output strobes equals the number of accepted inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Input sample strobe |
| re_in | input | WL | Real part, signed |
| im_in | input | WL | Imaginary part, signed |
| valid_out | output | 1 | Output sample strobe |
| magnitude | output | WL+1 | Vector length, unsigned integer |
| angle | output | WL+3 | Phase, signed, radians or fraction of pi |

## Verification
Some properties are checked by assertions on every cycle:
- the folded vector satisfies 0 <= y <= x;
- x never shrinks across a micro-rotation;
- the magnitude sign bit stays clear;
- the count of samples in flight never exceeds the pipeline depth, and no output strobe appears with nothing in flight.

The bench scenarios cover what cannot be seen from one cycle. They check the exact latency per sample and the accuracy of magnitude and angle against real-valued atan2 and sqrt. They also cover correct unfolding in all four quadrants and both octant halves, the wrap at pi, axis and zero inputs, and the behaviour of the strobes across gaps and back-to-back bursts.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam longint PI_Q30    = 64'sd3373259426;
    localparam longint INVPI_Q30 = 64'sd341782638;

    typedef struct packed {
        logic nx;   // real part was negative
        logic ny;   // imaginary part was negative
        logic sw;   // |re| <= |im|, operands swapped
    } fold_flags_t;

    // atan(2^-i) in Q32 by its odd power series (i >= 1)
    function automatic longint atan_q32(input int i);
        longint acc;
        longint term;
        int sh;
        acc = 0;
        for (int k = 1; k < 64; k += 2) begin
            sh = 32 - k * i;
            if (sh >= 0) begin
                term = (longint'(1) << sh) / k;
                if (((k - 1) / 2) % 2 == 0) acc = acc + term;
                else acc = acc - term;
            end
        end
        return acc;
    endfunction

    // rotation step in angle units with zf fraction bits
    function automatic longint angle_step(input int i, input int zf, input bit rad);
        longint a;
        a = atan_q32(i);
        if (rad) return (a + (longint'(1) << (31 - zf))) >>> (32 - zf);
        return (a * INVPI_Q30 + (longint'(1) << (61 - zf))) >>> (62 - zf);
    endfunction

    function automatic longint pi_units(input int zf, input bit rad);
        if (rad) return (PI_Q30 + (longint'(1) << (29 - zf))) >>> (30 - zf);
        return longint'(1) << zf;
    endfunction

    // 1 / prod sqrt(1 + 2^-2i), i = 1..n, rounded to cf fraction bits
    function automatic longint inv_gain(input int n, input int cf);
        longint a;
        longint r;
        longint t;
        a = longint'(1) << 30;
        for (int i = 1; i <= n; i++) a = a + (a >>> (2 * i));
        r = 64'sd923417968;
        for (int it = 0; it < 8; it++) begin
            t = (a * r) >>> 30;
            t = (t * r) >>> 30;
            r = (r * ((longint'(3) << 30) - t)) >>> 31;
        end
        return (r + (longint'(1) << (29 - cf))) >>> (30 - cf);
    endfunction

    // canonical signed digit recoding: mask of +1 or -1 digits
    function automatic longint csd_mask(input longint value, input bit want_neg);
        longint m;
        longint v;
        m = 0;
        v = value;
        for (int b = 0; b < 62; b++) begin
            if (v[0]) begin
                if (v[1]) begin
                    if (want_neg) m = m | (longint'(1) << b);
                    v = v + 1;
                end else begin
                    if (!want_neg) m = m | (longint'(1) << b);
                    v = v - 1;
                end
            end
            v = v >>> 1;
        end
        return m;
    endfunction

endpackage

// File: rtl/cmp_fold.sv
module cmp_fold #(
    parameter int WL = 16,
    parameter int IW = 22,
    parameter int G  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_i,
    input  logic signed [WL-1:0]     re_i,
    input  logic signed [WL-1:0]     im_i,
    output logic                     valid_o,
    output cmp_pkg::fold_flags_t     flags_o,
    output logic signed [IW-1:0]     x_o,
    output logic signed [IW-1:0]     y_o
);
    typedef struct packed {
        logic                 v;
        cmp_pkg::fold_flags_t f;
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
    } st_t;

    st_t st_d, st_q;
    logic signed [IW-1:0] sre, sim, are, aim;

    always_comb begin
        sre = {{(IW-WL){re_i[WL-1]}}, re_i};
        sim = {{(IW-WL){im_i[WL-1]}}, im_i};
        are = re_i[WL-1] ? -sre : sre;
        aim = im_i[WL-1] ? -sim : sim;
        st_d.v    = valid_i;
        st_d.f.nx = re_i[WL-1];
        st_d.f.ny = im_i[WL-1];
        st_d.f.sw = !(are > aim);
        st_d.x    = (st_d.f.sw ? aim : are) <<< G;
        st_d.y    = (st_d.f.sw ? are : aim) <<< G;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.v;
    assign flags_o = st_q.f;
    assign x_o     = st_q.x;
    assign y_o     = st_q.y;

    // R1: folded operand lies in the first half-quadrant
    a_r1_folded_order: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (y_o >= 0 && y_o <= x_o));

endmodule

// File: rtl/cmp_iter.sv
module cmp_iter #(
    parameter int IW    = 22,
    parameter int ZW    = 23,
    parameter int SHIFT = 1,
    parameter logic signed [ZW-1:0] STEP = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_i,
    input  cmp_pkg::fold_flags_t     flags_i,
    input  logic signed [IW-1:0]     x_i,
    input  logic signed [IW-1:0]     y_i,
    input  logic signed [ZW-1:0]     z_i,
    output logic                     valid_o,
    output cmp_pkg::fold_flags_t     flags_o,
    output logic signed [IW-1:0]     x_o,
    output logic signed [IW-1:0]     y_o,
    output logic signed [ZW-1:0]     z_o
);
    typedef struct packed {
        logic                 v;
        cmp_pkg::fold_flags_t f;
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
        logic signed [ZW-1:0] z;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.v = valid_i;
        st_d.f = flags_i;
        if (!y_i[IW-1]) begin
            st_d.x = x_i + (y_i >>> SHIFT);
            st_d.y = y_i - (x_i >>> SHIFT);
            st_d.z = z_i + STEP;
        end else begin
            st_d.x = x_i - (y_i >>> SHIFT);
            st_d.y = y_i + (x_i >>> SHIFT);
            st_d.z = z_i - STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.v;
    assign flags_o = st_q.f;
    assign x_o     = st_q.x;
    assign y_o     = st_q.y;
    assign z_o     = st_q.z;

    // R2: a vectoring micro-rotation never shortens x
    a_r2_x_grows: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (x_o >= $past(x_i)));

endmodule

// File: rtl/cmp_unfold.sv
module cmp_unfold #(
    parameter int WL        = 16,
    parameter int IW        = 22,
    parameter int ZW        = 23,
    parameter int ZF        = 22,
    parameter int G         = 4,
    parameter int N         = 15,
    parameter int CF        = 20,
    parameter bit RAD       = 1'b0,
    parameter bit GAIN_COMP = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_i,
    input  cmp_pkg::fold_flags_t     flags_i,
    input  logic signed [IW-1:0]     x_i,
    input  logic signed [ZW-1:0]     z_i,
    output logic                     valid_o,
    output logic [WL:0]              mag_o,
    output logic [WL+2:0]            ang_o
);
    localparam logic [ZW-1:0] PI_Z   = ZW'(cmp_pkg::pi_units(ZF, RAD));
    localparam logic [ZW-1:0] HALF_Z = PI_Z >> 1;
    localparam int            PW     = IW + CF + 2;

    typedef struct packed {
        logic                 v;
        cmp_pkg::fold_flags_t f;
        logic signed [IW-1:0] mag;
        logic [ZW-1:0]        ang;
    } sa_t;

    typedef struct packed {
        logic          v;
        logic [WL:0]   mag;
        logic [WL+2:0] ang;
    } sb_t;

    sa_t sa_d, sa_q;
    sb_t sb_d, sb_q;
    logic signed [IW-1:0] scaled;
    logic [ZW-1:0] quad, rang;
    logic [IW-1:0] rmag;

    if (GAIN_COMP) begin : g_gain
        localparam longint        KQ = cmp_pkg::inv_gain(N, CF);
        localparam logic [63:0]   PM = 64'(cmp_pkg::csd_mask(KQ, 1'b0));
        localparam logic [63:0]   NM = 64'(cmp_pkg::csd_mask(KQ, 1'b1));
        logic signed [PW-1:0] xe, acc;
        always_comb begin
            xe = {{(PW-IW){x_i[IW-1]}}, x_i};
            acc = '0;
            acc[CF-1] = 1'b1;
            for (int b = 0; b <= CF + 1; b++) begin
                if (PM[b]) acc = acc + (xe <<< b);
                if (NM[b]) acc = acc - (xe <<< b);
            end
        end
        assign scaled = acc[CF+IW-1:CF];
    end else begin : g_raw
        assign scaled = x_i;
    end

    // stage A: octant correction and gain removal
    always_comb begin
        sa_d.v   = valid_i;
        sa_d.f   = flags_i;
        sa_d.mag = scaled;
        sa_d.ang = flags_i.sw ? (HALF_Z - z_i) : z_i;
    end

    // stage B: quadrant correction and rounding
    always_comb begin
        case ({sa_q.f.nx, sa_q.f.ny})
            2'b11:   quad = sa_q.ang - PI_Z;
            2'b10:   quad = PI_Z - sa_q.ang;
            2'b01:   quad = -sa_q.ang;
            default: quad = sa_q.ang;
        endcase
        rang = quad + ZW'(1 << (G - 1));
        rmag = sa_q.mag + IW'(1 << (G - 1));
        sb_d.v   = sa_q.v;
        sb_d.ang = rang[ZW-1:G];
        sb_d.mag = rmag[WL+G:G];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sa_q <= '0;
            sb_q <= '0;
        end else begin
            sa_q <= sa_d;
            sb_q <= sb_d;
        end
    end

    assign valid_o = sb_q.v;
    assign mag_o   = sb_q.mag;
    assign ang_o   = sb_q.ang;

endmodule

// File: rtl/cmp_polar.sv
module cmp_polar #(
    parameter int WL            = 16,
    parameter int NITER         = WL - 1,
    parameter int GUARD         = 4,
    parameter bit ANGLE_RADIANS = 1'b0,
    parameter bit GAIN_COMP     = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_in,
    input  logic signed [WL-1:0] re_in,
    input  logic signed [WL-1:0] im_in,
    output logic                 valid_out,
    output logic [WL:0]          magnitude,
    output logic [WL+2:0]        angle
);
    localparam int LAT = NITER + 4;
    localparam int IW  = WL + GUARD + 2;
    localparam int ZW  = WL + 3 + GUARD;
    localparam int ZF  = (ANGLE_RADIANS ? WL : WL + 2) + GUARD;
    localparam int CF  = WL + 4;
    localparam int CW  = $clog2(LAT + 2) + 1;

    typedef struct packed {
        logic                 v;
        logic signed [WL-1:0] re;
        logic signed [WL-1:0] im;
        logic [CW-1:0]        infl;
    } top_t;

    top_t tp_d, tp_q;

    logic                 vs [0:NITER];
    cmp_pkg::fold_flags_t fs [0:NITER];
    logic signed [IW-1:0] xs [0:NITER];
    logic signed [IW-1:0] ys [0:NITER];
    logic signed [ZW-1:0] zs [0:NITER];

    always_comb begin
        tp_d.v    = valid_in;
        tp_d.re   = re_in;
        tp_d.im   = im_in;
        tp_d.infl = tp_q.infl + CW'(valid_in) - CW'(valid_out);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tp_q <= '0;
        else        tp_q <= tp_d;
    end

    cmp_fold #(.WL(WL), .IW(IW), .G(GUARD)) u_fold (
        .clk(clk), .rst_n(rst_n), .valid_i(tp_q.v), .re_i(tp_q.re), .im_i(tp_q.im),
        .valid_o(vs[0]), .flags_o(fs[0]), .x_o(xs[0]), .y_o(ys[0])
    );
    assign zs[0] = '0;

    for (genvar i = 1; i <= NITER; i++) begin : g_iter
        localparam logic signed [ZW-1:0] STP =
            ZW'(cmp_pkg::angle_step(i, ZF, ANGLE_RADIANS));
        cmp_iter #(.IW(IW), .ZW(ZW), .SHIFT(i), .STEP(STP)) u_it (
            .clk(clk), .rst_n(rst_n),
            .valid_i(vs[i-1]), .flags_i(fs[i-1]),
            .x_i(xs[i-1]), .y_i(ys[i-1]), .z_i(zs[i-1]),
            .valid_o(vs[i]), .flags_o(fs[i]),
            .x_o(xs[i]), .y_o(ys[i]), .z_o(zs[i])
        );
    end

    cmp_unfold #(.WL(WL), .IW(IW), .ZW(ZW), .ZF(ZF), .G(GUARD), .N(NITER), .CF(CF),
                 .RAD(ANGLE_RADIANS), .GAIN_COMP(GAIN_COMP)) u_unfold (
        .clk(clk), .rst_n(rst_n),
        .valid_i(vs[NITER]), .flags_i(fs[NITER]), .x_i(xs[NITER]), .z_i(zs[NITER]),
        .valid_o(valid_out), .mag_o(magnitude), .ang_o(angle)
    );

    // R4: the length is never negative
    a_r4_mag_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> !magnitude[WL]);

    // R3: no more samples in flight than the pipeline holds
    a_r3_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tp_q.infl <= CW'(LAT + 1));

    // R11: an output strobe always has an accepted input behind it
    a_r11_out_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (tp_q.infl != '0));

endmodule

// File: tb/sim_cmp_polar.sv
module sim_cmp_polar;
    localparam int  CLK_P = 10;
    localparam int  WL    = 16;
    localparam int  N     = WL - 1;
    localparam int  LAT   = N + 4;
    localparam real PI    = 3.14159265358979;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vin = 1'b0;
    logic signed [WL-1:0] re = '0, im = '0;
    logic v0, v1;
    logic [WL:0] m0, m1;
    logic [WL+2:0] a0, a1;

    always #(CLK_P/2) clk = ~clk;

    cmp_polar #(.WL(WL), .ANGLE_RADIANS(1'b0), .GAIN_COMP(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .valid_in(vin), .re_in(re), .im_in(im),
        .valid_out(v0), .magnitude(m0), .angle(a0));
    cmp_polar #(.WL(WL), .ANGLE_RADIANS(1'b1), .GAIN_COMP(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .valid_in(vin), .re_in(re), .im_in(im),
        .valid_out(v1), .magnitude(m1), .angle(a1));

    int errs = 0, checks = 0, cyc = 0, wr = 0, rd = 0;
    bit done = 1'b0;
    int q_re [0:2047];
    int q_im [0:2047];
    int q_t  [0:2047];
    int q_k  [0:2047];
    real kgain = 1.0;

    int cr, ci, ck;
    real hyp, ex, d, tol, act;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input real actual, input real expected);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0f expected=%0f", req, what, actual, expected);
        end
    endtask

    function automatic real wrap2(input real v);
        real w;
        w = v;
        while (w > 262144.0) w = w - 524288.0;
        while (w < -262144.0) w = w + 524288.0;
        return w;
    endfunction

    function automatic real absr(input real v);
        return (v < 0.0) ? -v : v;
    endfunction

    task automatic send(input int r, input int i, input int kind);
        @(negedge clk);
        re = WL'(r);
        im = WL'(i);
        vin = 1'b1;
        q_re[wr] = r; q_im[wr] = i; q_t[wr] = cyc; q_k[wr] = kind;
        wr++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            vin = 1'b0;
        end
    endtask

    // output checker
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (v0 !== v1) check(1'b0, "R3", "strobe alignment", real'(v1), real'(v0));
            if (v0 === 1'b1) begin
                if (rd >= wr) check(1'b0, "R11", "strobe without input", real'(rd), real'(wr));
                else begin
                    cr = q_re[rd]; ci = q_im[rd]; ck = q_k[rd];
                    hyp = $sqrt(real'(cr) * cr + real'(ci) * ci);
                    check(cyc - q_t[rd] == LAT, "R3", "latency",
                          real'(cyc - q_t[rd]), real'(LAT));
                    act = real'(m0);
                    if (ck == 2) check(m0 == '0, "R10", "zero magnitude", act, 0.0);
                    else check(absr(act - hyp) <= 3.0 + hyp * 1e-5,
                               (ck == 1) ? "R9" : "R4", "magnitude", act, hyp);
                    act = real'(m1);
                    ex = hyp * kgain;
                    check(absr(act - ex) <= 3.0 + ex * 1e-5, "R5", "raw magnitude", act, ex);
                    if (hyp >= 64.0) begin
                        tol = 2.0 / hyp + 6e-5;
                        ex = $atan2(real'(ci), real'(cr));
                        act = real'($signed(a0));
                        d = wrap2(act - ex / PI * 262144.0);
                        check(absr(d) <= tol / PI * 262144.0 + 2.0,
                              (ck == 1) ? "R9" : ((cr < 0 ? -cr : cr) <= (ci < 0 ? -ci : ci)) ? "R1" : "R6",
                              "normalized angle", act, ex / PI * 262144.0);
                        act = real'($signed(a1));
                        check(absr(act - ex * 65536.0) <= tol * 65536.0 + 2.0,
                              (cr < 0 || ci < 0) ? "R8" : "R7", "radian angle", act, ex * 65536.0);
                    end
                    rd++;
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1'b1;
            errs++;
            $display("FAIL R3 watchdog: actual=%0d expected=%0d", rd, wr);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 1; i <= N; i++) kgain = kgain * $sqrt(1.0 + 2.0 ** (-2.0 * i));
        void'($urandom(32'd2024));
        vin = 1'b1;
        repeat (3) @(negedge clk);
        check(v0 == 1'b0 && v1 == 1'b0, "R3", "strobe low in reset", real'(v0), 0.0);
        vin = 1'b0;
        rst_n = 1'b1;
        for (int k = 0; k < LAT + 3; k++) begin
            @(negedge clk);
            if (k == LAT + 2) check(v0 == 1'b0, "R11", "no strobe without input", real'(v0), 0.0);
        end
        // axis and zero cases
        send(0, 0, 2);
        send(12000, 0, 1);   send(-12000, 0, 1);
        send(0, 12000, 1);   send(0, -12000, 1);
        send(-32768, 0, 1);  send(0, -32768, 1);
        send(32767, 0, 1);   send(0, 32767, 1);
        // every octant, diagonal ties and extreme corner
        send(30000, 1000, 0);   send(1000, 30000, 0);
        send(-30000, 1000, 0);  send(-1000, 30000, 0);
        send(-30000, -1000, 0); send(-1000, -30000, 0);
        send(30000, -1000, 0);  send(1000, -30000, 0);
        send(20000, 20000, 0);  send(-20000, 20000, 0);
        send(-32768, -32768, 0); send(-32768, -1, 0);
        idle(2);
        // random stream with gaps and back-to-back bursts
        for (int n = 0; n < 400; n++) begin
            send(int'($signed(WL'($urandom))), int'($signed(WL'($urandom))), 0);
            if ($urandom % 5 == 0) idle(1 + int'($urandom % 3));
        end
        idle(LAT + 6);
        check(rd == wr, "R2", "all accepted samples emerged", real'(rd), real'(wr));
        check(rd == wr, "R11", "strobe count equals input count", real'(rd), real'(wr));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule